// File: doc/BRIEF.md
# Control Register File with Banked Stack Pointer

This block holds the control registers of a small processor core. The core reads them through a 4-bit index on a combinational read port and writes them through a 4-bit index on a synchronous write port. The registers are a packed 16-bit status word, a condition flag, two backup program counters, a second-level backup status byte, two plain scratch words and two stack-pointer shadows.

The status word is built from three stored fields: a backup byte, a status byte and the condition flag. Bit 7 of the status byte selects the stack mode. When a status write flips that bit, the block swaps the live stack pointer with one of the two shadows. The live stack pointer itself lives in the general register file outside this block. The block reads it on `sp_live_i` and updates it through `sp_live_o` / `sp_live_we`, so the update lands in the same clock edge as the write that caused it. The two stack-pointer indices are aliases: each one resolves either to the live register or to its shadow, depending on the current mode.

Top module: `ctlreg_file`

## Requirements
- R1: After reset every stored register, both shadows and the stack mode are 0, so every index reads 0.
- R2: Index 0 (status) reads `{16'b0, backup & 8'hC1, (status & 8'hC0) | cond}`, where bit 0 of the result is the condition flag.
- R3: A write to index 0 loads wr_data[15:8] into the backup byte and wr_data[7:0] into the status byte, and sets the condition flag from wr_data[0]. The stack mode is status bit 7. The live stack pointer is updated only when the write changes that bit.
- R4: When stack mode changes from 1 to 0, the current live stack pointer is saved into the user shadow, and in the same edge the live stack pointer receives the interrupt shadow.
- R5: When stack mode changes from 0 to 1, the current live stack pointer is saved into the interrupt shadow, and in the same edge the live stack pointer receives the user shadow.
- R6: Index 2 (interrupt stack pointer) reads and writes the live stack pointer when stack mode is 0, and the interrupt shadow when it is 1.
- R7: Index 3 (user stack pointer) reads and writes the live stack pointer when stack mode is 1, and the user shadow when it is 0.
- R8: Indices 6 (backup PC) and 7 (second backup PC) store all 32 written bits and read back with bit 0 forced to 0.
- R9: Index 8 (second backup status) stores wr_data[7:0] and reads back that byte masked with 8'hC1.
- R10: Index 1 (condition) reads the flag in bit 0 with zeros above it. A write to it sets the flag from wr_data[0] only and leaves the status and backup bytes and the stack mode unchanged.
- R11: Indices 4 and 5 are independent 32-bit storage. Indices 9 to 15 read 0, and writes to them change nothing.
- R12: A read and a write to the same index in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx | input | 4 | Read index |
| rd_data | output | 32 | Read data, combinational from rd_idx and state |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Write index |
| wr_data | input | 32 | Write data |
| sp_live_i | input | 32 | Current value of the external live stack pointer |
| sp_live_o | output | 32 | New value for the live stack pointer |
| sp_live_we | output | 1 | Load strobe for the live stack pointer |

## Verification
A wrong stack mode or a lost shadow value does not show up on the status read alone. It appears at the ports one edge after the next mode flip, when the live pointer receives the wrong word, or at once on a read of index 2 or 3, which then selects the wrong source. For that reason the checks read both stack aliases and the external live pointer after every swap and after every alias write. Masking faults appear on the same cycle as the read of the affected index. A read-during-write hazard appears as the new value showing up one cycle early.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

    localparam int unsigned CR_DW  = 32;
    localparam int unsigned CR_IW  = 4;
    localparam int unsigned SM_BIT = 7;

    localparam logic [7:0] STAT_KEEP   = 8'hC0;
    localparam logic [7:0] BKSTAT_KEEP = 8'hC1;

    typedef enum logic [3:0] {
        CR_STATUS  = 4'd0,
        CR_COND    = 4'd1,
        CR_ISP     = 4'd2,
        CR_USP     = 4'd3,
        CR_SCR0    = 4'd4,
        CR_SCR1    = 4'd5,
        CR_BKPC    = 4'd6,
        CR_BBKPC   = 4'd7,
        CR_BBKSTAT = 4'd8
    } cr_idx_e;

    // bank index equals the stack-mode value that makes the bank live
    localparam int unsigned BANK_INT  = 0;
    localparam int unsigned BANK_USER = 1;

    typedef struct packed {
        logic [7:0] bk;
        logic [7:0] st;
        logic       cond;
    } status_t;

    function automatic logic [15:0] pack_status(status_t s);
        return {s.bk & BKSTAT_KEEP, (s.st & STAT_KEEP) | {7'b0, s.cond}};
    endfunction

endpackage

// File: rtl/ctlreg_status.sv
module ctlreg_status
    import ctlreg_pkg::*;
#(
    parameter int unsigned IW = CR_IW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_go,
    input  logic [IW-1:0] wr_idx,
    input  logic [15:0]   wr_word,
    output status_t       stat_q,
    output logic          sm,
    output logic          swap_req
);

    logic hit_status;
    logic hit_cond;

    assign hit_status = wr_go && (wr_idx == IW'(CR_STATUS));
    assign hit_cond   = wr_go && (wr_idx == IW'(CR_COND));
    assign sm         = stat_q.st[SM_BIT];
    assign swap_req   = hit_status && (wr_word[SM_BIT] != sm);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else if (hit_status) begin
            stat_q.bk   <= wr_word[15:8];
            stat_q.st   <= wr_word[7:0];
            stat_q.cond <= wr_word[0];
        end else if (hit_cond) begin
            stat_q.cond <= wr_word[0];
        end
    end

endmodule

// File: rtl/ctlreg_stack_bank.sv
module ctlreg_stack_bank
    import ctlreg_pkg::*;
#(
    parameter int unsigned DW = CR_DW
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sm,
    input  logic                swap_req,
    input  logic [1:0]          alias_wr,
    input  logic [DW-1:0]       wr_data,
    input  logic [DW-1:0]       sp_live_i,
    output logic [DW-1:0]       sp_live_o,
    output logic                sp_live_we,
    output logic [1:0][DW-1:0]  view
);

    localparam int unsigned NBANK = 2;

    logic [DW-1:0]    sh_q  [NBANK];
    logic [NBANK-1:0] sh_we;
    logic [DW-1:0]    sh_d  [NBANK];

    always_comb begin
        sp_live_we = 1'b0;
        sp_live_o  = wr_data;
        for (int b = 0; b < NBANK; b++) begin
            sh_we[b] = 1'b0;
            sh_d[b]  = wr_data;
        end
        if (swap_req) begin
            // park the live value in the bank of the outgoing mode,
            // bring in the bank of the incoming mode
            sp_live_we          = 1'b1;
            sp_live_o           = sh_q[int'(!sm)];
            sh_we[int'(sm)]     = 1'b1;
            sh_d[int'(sm)]      = sp_live_i;
        end else begin
            for (int b = 0; b < NBANK; b++) begin
                if (alias_wr[b]) begin
                    if (int'(sm) == b) begin
                        sp_live_we = 1'b1;
                        sp_live_o  = wr_data;
                    end else begin
                        sh_we[b] = 1'b1;
                    end
                end
            end
        end
    end

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst)
                sh_q[g] <= '0;
            else if (sh_we[g])
                sh_q[g] <= sh_d[g];
        end
        assign view[g] = (int'(sm) == g) ? sp_live_i : sh_q[g];
    end

endmodule

// File: rtl/ctlreg_backup.sv
module ctlreg_backup
    import ctlreg_pkg::*;
#(
    parameter int unsigned DW   = CR_DW,
    parameter int unsigned IW   = CR_IW,
    parameter int unsigned NSCR = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_go,
    input  logic [IW-1:0]         wr_idx,
    input  logic [DW-1:0]         wr_data,
    output logic [DW-1:0]         bkpc_rd,
    output logic [DW-1:0]         bbkpc_rd,
    output logic [7:0]            bbkstat_rd,
    output logic [NSCR-1:0][DW-1:0] scr_rd
);

    localparam int unsigned SCR_BASE = int'(CR_SCR0);

    logic [DW-1:0] bkpc_q;
    logic [DW-1:0] bbkpc_q;
    logic [7:0]    bbkstat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bkpc_q    <= '0;
            bbkpc_q   <= '0;
            bbkstat_q <= '0;
        end else if (wr_go) begin
            if (wr_idx == IW'(CR_BKPC))    bkpc_q    <= wr_data;
            if (wr_idx == IW'(CR_BBKPC))   bbkpc_q   <= wr_data;
            if (wr_idx == IW'(CR_BBKSTAT)) bbkstat_q <= wr_data[7:0];
        end
    end

    for (genvar g = 0; g < NSCR; g++) begin : g_scr
        logic [DW-1:0] scr_q;
        always_ff @(posedge clk) begin
            if (rst)
                scr_q <= '0;
            else if (wr_go && (wr_idx == IW'(SCR_BASE + g)))
                scr_q <= wr_data;
        end
        assign scr_rd[g] = scr_q;
    end

    assign bkpc_rd    = {bkpc_q[DW-1:1], 1'b0};
    assign bbkpc_rd   = {bbkpc_q[DW-1:1], 1'b0};
    assign bbkstat_rd = bbkstat_q & BKSTAT_KEEP;

endmodule

// File: rtl/ctlreg_file.sv
module ctlreg_file
    import ctlreg_pkg::*;
#(
    parameter int unsigned DW = CR_DW,
    parameter int unsigned IW = CR_IW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] rd_idx,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] sp_live_i,
    output logic [DW-1:0] sp_live_o,
    output logic          sp_live_we
);

    localparam int unsigned NSCR = 2;

    logic                   wr_go;
    status_t                stat_w;
    logic                   sm_w;
    logic                   swap_w;
    logic [1:0]             alias_wr;
    logic [1:0][DW-1:0]     sp_view;
    logic [DW-1:0]          bkpc_w;
    logic [DW-1:0]          bbkpc_w;
    logic [7:0]             bbkstat_w;
    logic [NSCR-1:0][DW-1:0] scr_w;

    assign wr_go = wr_en && !rst;
    assign alias_wr[BANK_INT]  = wr_go && (wr_idx == IW'(CR_ISP));
    assign alias_wr[BANK_USER] = wr_go && (wr_idx == IW'(CR_USP));

    ctlreg_status #(.IW(IW)) status_i (
        .clk      (clk),
        .rst      (rst),
        .wr_go    (wr_go),
        .wr_idx   (wr_idx),
        .wr_word  (wr_data[15:0]),
        .stat_q   (stat_w),
        .sm       (sm_w),
        .swap_req (swap_w)
    );

    ctlreg_stack_bank #(.DW(DW)) bank_i (
        .clk        (clk),
        .rst        (rst),
        .sm         (sm_w),
        .swap_req   (swap_w),
        .alias_wr   (alias_wr),
        .wr_data    (wr_data),
        .sp_live_i  (sp_live_i),
        .sp_live_o  (sp_live_o),
        .sp_live_we (sp_live_we),
        .view       (sp_view)
    );

    ctlreg_backup #(.DW(DW), .IW(IW), .NSCR(NSCR)) backup_i (
        .clk        (clk),
        .rst        (rst),
        .wr_go      (wr_go),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .bkpc_rd    (bkpc_w),
        .bbkpc_rd   (bbkpc_w),
        .bbkstat_rd (bbkstat_w),
        .scr_rd     (scr_w)
    );

    always_comb begin
        rd_data = '0;
        case (rd_idx)
            IW'(CR_STATUS):  rd_data = DW'(pack_status(stat_w));
            IW'(CR_COND):    rd_data = DW'(stat_w.cond);
            IW'(CR_ISP):     rd_data = sp_view[BANK_INT];
            IW'(CR_USP):     rd_data = sp_view[BANK_USER];
            IW'(CR_SCR0):    rd_data = scr_w[0];
            IW'(CR_SCR1):    rd_data = scr_w[1];
            IW'(CR_BKPC):    rd_data = bkpc_w;
            IW'(CR_BBKPC):   rd_data = bbkpc_w;
            IW'(CR_BBKSTAT): rd_data = DW'(bbkstat_w);
            default:         rd_data = '0;
        endcase
    end

endmodule

// File: rtl/ctlreg_file_chk.sv
module ctlreg_file_chk
    import ctlreg_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [3:0]  wr_idx,
    input logic        wr_sm_bit,
    input logic [3:0]  rd_idx,
    input logic [31:0] rd_data,
    input logic        sp_live_we,
    input logic        sm
);

    logic st_wr;
    assign st_wr = wr_en && (wr_idx == CR_STATUS);

    // R3: a status write that flips the mode bit drives the live pointer
    a_r3_swap_on_flip: assert property (@(posedge clk) disable iff (rst)
        (st_wr && (wr_sm_bit != sm)) |-> sp_live_we);

    // R3: a status write that keeps the mode leaves the live pointer alone
    a_r3_no_swap_same: assert property (@(posedge clk) disable iff (rst)
        (st_wr && (wr_sm_bit == sm)) |-> !sp_live_we);

    // R3: the mode follows the written bit
    a_r3_mode_follows: assert property (@(posedge clk) disable iff (rst)
        st_wr |=> (sm == $past(wr_sm_bit)));

    // R6 / R7: live pointer only moves on status or stack-alias writes
    a_r6_live_we_source: assert property (@(posedge clk) disable iff (rst)
        sp_live_we |-> (wr_en && (wr_idx == CR_STATUS || wr_idx == CR_ISP || wr_idx == CR_USP)));

    // R2: status read has only the kept bits and shows the mode
    a_r2_status_shape: assert property (@(posedge clk) disable iff (rst)
        (rd_idx == CR_STATUS) |-> (((rd_data & ~32'h0000C1C1) == 32'h0) && (rd_data[7] == sm)));

    // R8: backup PCs always read even
    a_r8_pc_even: assert property (@(posedge clk) disable iff (rst)
        (rd_idx == CR_BKPC || rd_idx == CR_BBKPC) |-> !rd_data[0]);

    // R10: condition index only has bit 0
    a_r10_cond_width: assert property (@(posedge clk) disable iff (rst)
        (rd_idx == CR_COND) |-> (rd_data[31:1] == 31'h0));

    // R11: unmapped indices read zero
    a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_idx > 4'd8) |-> (rd_data == 32'h0));

endmodule

bind ctlreg_file ctlreg_file_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_sm_bit  (wr_data[7]),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .sp_live_we (sp_live_we),
    .sm         (sm_w)
);

// File: tb/ctlreg_file_tb_top.sv
`timescale 1ns/1ps
module ctlreg_file_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] sp_ext;
    logic [31:0] sp_live_o;
    logic        sp_live_we;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        bit          live;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t exp_q[$];

    always #2 clk = ~clk;   // 250 MHz

    ctlreg_file dut_i (
        .clk        (clk),
        .rst        (rst),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .sp_live_i  (sp_ext),
        .sp_live_o  (sp_live_o),
        .sp_live_we (sp_live_we)
    );

    // external live stack pointer, as the general register file would hold it
    always_ff @(posedge clk) begin
        if (rst)             sp_ext <= '0;
        else if (sp_live_we) sp_ext <= sp_live_o;
    end

    // monitor: compare one expected item per cycle, mid-cycle
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            item_t it;
            logic [31:0] got;
            it  = exp_q.pop_front();
            got = it.live ? sp_ext : rd_data;
            n_checks++;
            if (got !== it.exp) begin
                n_fail++;
                $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
            end
        end
    end

    task automatic wr(input logic [3:0] idx, input logic [31:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
    endtask

    task automatic rd(input logic [3:0] idx, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        wr_en = 1'b0; rd_idx = idx;
        exp_q.push_back('{1'b0, e, tag});
    endtask

    task automatic live(input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        wr_en = 1'b0;
        exp_q.push_back('{1'b1, e, tag});
    endtask

    task automatic wr_rd(input logic [3:0] idx, input logic [31:0] d,
                         input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_idx = idx; wr_data = d; rd_idx = idx;
        exp_q.push_back('{1'b0, e, tag});
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        rd(4'd0, 32'h0, "R1 status");
        rd(4'd2, 32'h0, "R1 isp");
        rd(4'd3, 32'h0, "R1 usp");
        rd(4'd6, 32'h0, "R1 bkpc");
        rd(4'd8, 32'h0, "R1 bbkstat");
        live(32'h0, "R1 live sp");

        // R6 / R7 in mode 0
        wr(4'd2, 32'h0000_1000);
        live(32'h0000_1000, "R6 isp alias write goes live");
        rd(4'd2, 32'h0000_1000, "R6 isp reads live in mode 0");
        wr(4'd3, 32'h0000_2000);
        rd(4'd3, 32'h0000_2000, "R7 usp reads shadow in mode 0");
        live(32'h0000_1000, "R7 usp shadow write leaves live");

        // R2 / R3 / R5: flip to mode 1
        wr(4'd0, 32'hABCD_FF81);
        rd(4'd0, 32'h0000_C181, "R2 status packing");
        live(32'h0000_2000, "R5 live takes user shadow");
        rd(4'd2, 32'h0000_1000, "R5 isp shadow holds old live");
        rd(4'd3, 32'h0000_2000, "R7 usp reads live in mode 1");

        // R6 / R7 in mode 1
        wr(4'd3, 32'h0000_2F00);
        live(32'h0000_2F00, "R7 usp alias write goes live");
        wr(4'd2, 32'h0000_1F00);
        rd(4'd2, 32'h0000_1F00, "R6 isp reads shadow in mode 1");
        live(32'h0000_2F00, "R6 isp shadow write leaves live");

        // R3: status write keeping mode does not swap
        wr(4'd0, 32'h0000_0080);
        rd(4'd0, 32'h0000_0080, "R3 status rewrite");
        live(32'h0000_2F00, "R3 no swap without mode change");

        // R4: flip back to mode 0
        wr(4'd0, 32'h0000_0041);
        rd(4'd0, 32'h0000_0041, "R3 status low bits");
        live(32'h0000_1F00, "R4 live takes interrupt shadow");
        rd(4'd3, 32'h0000_2F00, "R4 user shadow holds old live");
        rd(4'd2, 32'h0000_1F00, "R4 isp reads live");

        // R10: condition index
        wr(4'd1, 32'hFFFF_FFFE);
        rd(4'd1, 32'h0, "R10 cond cleared from bit0");
        rd(4'd0, 32'h0000_0040, "R10 status follows cond");
        wr(4'd1, 32'h0000_0001);
        rd(4'd1, 32'h1, "R10 cond set");
        rd(4'd0, 32'h0000_0041, "R10 status bytes untouched");
        live(32'h0000_1F00, "R10 no swap from cond write");

        // R8: backup PCs
        wr(4'd6, 32'hDEAD_BEEF);
        rd(4'd6, 32'hDEAD_BEEE, "R8 bkpc lsb masked");
        wr(4'd7, 32'h1234_5679);
        rd(4'd7, 32'h1234_5678, "R8 bbkpc lsb masked");
        wr(4'd6, 32'h8000_0003);
        rd(4'd6, 32'h8000_0002, "R8 bkpc full width");

        // R9: second backup status
        wr(4'd8, 32'hFFFF_FFFF);
        rd(4'd8, 32'h0000_00C1, "R9 bbkstat mask");
        wr(4'd8, 32'h0000_003E);
        rd(4'd8, 32'h0, "R9 bbkstat masked bits");

        // R11: scratch and unmapped
        wr(4'd4, 32'hCAFE_F00D);
        wr(4'd5, 32'h5A5A_5A5A);
        rd(4'd4, 32'hCAFE_F00D, "R11 scratch0");
        rd(4'd5, 32'h5A5A_5A5A, "R11 scratch1");
        wr(4'd12, 32'hFFFF_FFFF);
        rd(4'd12, 32'h0, "R11 unmapped reads 0");
        rd(4'd9, 32'h0, "R11 unmapped 9 reads 0");
        rd(4'd4, 32'hCAFE_F00D, "R11 unmapped write ignored scr");
        rd(4'd0, 32'h0000_0041, "R11 unmapped write ignored status");
        live(32'h0000_1F00, "R11 unmapped write ignored live");

        // R12: read during write
        wr_rd(4'd4, 32'h1111_1111, 32'hCAFE_F00D, "R12 old value same cycle");
        rd(4'd4, 32'h1111_1111, "R12 new value next cycle");
        wr_rd(4'd0, 32'h0000_0000, 32'h0000_0041, "R12 status old value");
        rd(4'd0, 32'h0, "R12 status new value");

        @(posedge clk); #1;
        wr_en = 1'b0;
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule